// File: doc/BRIEF.md
# Load-Use and Branch Stall Tracker

This block watches an in-order instruction stream and works out the timing cost of two kinds of hazard. For every instruction it is offered, it receives an instruction class, up to two source register indices with a valid flag each, the destination register of a load, and a taken flag for control transfers. It remembers which register the previous instruction loaded. When a later source operand reads that register, it raises a hazard flag for that operand and charges a fixed load-use penalty to a cumulative counter. Control transfers are counted as taken or not taken, and each taken one charges a fixed branch penalty to a separate counter.

The block does not stall anything. It only observes the stream and produces flags and counts. Instructions arrive over a valid/ready handshake. `iss_ready` is high in every cycle except one in which `clr` is asserted. In such a cycle the offered instruction is not taken, and the source must hold it until ready returns. An instruction counts as accepted when `iss_valid` and `iss_ready` are both high at a rising clock edge.

Top module: `stall_tracker`

## Requirements
- R1: After reset, all four counters and `load_mask` read zero and `iss_ready` is high. When `clr` is high, `iss_ready` is low, the offered instruction is not accepted, and one cycle later all counters and `load_mask` read zero.
- R2: Each checked source operand whose register bit is set in `load_mask` adds 2 to `ld_stall_cnt`. If both operands hit, the instruction adds 4.
- R3: An operand whose valid flag is low never raises a hazard and never adds a stall, whatever its index.
- R4: `iss_kind` selects the operands that are checked. Execute (0), compare (1) and multiply-accumulate (2) check both operands. Control transfer (3) checks only operand A. Load (4), store (5) and the unused codes 6 and 7 check neither operand.
- R5: An accepted load (kind 4) leaves exactly bit `iss_ld_dst` set in `load_mask`, so that only the next accepted instruction sees it. Any other accepted instruction leaves `load_mask` at zero. While no instruction is accepted, `load_mask` holds its value.
- R6: An accepted control transfer with `iss_taken` high adds 2 to `br_stall_cnt` and 1 to `taken_cnt`. With `iss_taken` low it adds 1 to `untaken_cnt` only. For every other kind, `iss_taken` has no effect.
- R7: Every counter saturates at its all-ones value and never wraps.
- R8: `hazard_a` and `hazard_b` are combinational. Each is high in a cycle exactly when the offered instruction is accepted that cycle and the matching operand is checked, valid, and hits `load_mask`.
- R9: While `iss_valid` is low, the counters do not change and both hazard flags stay low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr | input | 1 | Synchronous clear of counters and load mask |
| iss_valid | input | 1 | An instruction is offered |
| iss_ready | output | 1 | Instruction can be accepted (low during clear) |
| iss_kind | input | 3 | Instruction class code |
| iss_src_a_vld | input | 1 | Operand A is present |
| iss_src_a | input | 4 | Operand A register index |
| iss_src_b_vld | input | 1 | Operand B is present |
| iss_src_b | input | 4 | Operand B register index |
| iss_ld_dst | input | 4 | Load destination register (used for kind 4) |
| iss_taken | input | 1 | Control transfer taken (used for kind 3) |
| hazard_a | output | 1 | Operand A hits a pending load |
| hazard_b | output | 1 | Operand B hits a pending load |
| load_mask | output | 16 | Registers loaded by the previous accepted instruction |
| ld_stall_cnt | output | 32 | Cumulative load-use stall cycles |
| br_stall_cnt | output | 32 | Cumulative taken-transfer stall cycles |
| taken_cnt | output | 32 | Taken control transfers |
| untaken_cnt | output | 32 | Not-taken control transfers |

## Verification
The bench targets the cases that are easy to get wrong. A load followed by a store, or by a second load, to the same register must add nothing; a design that checks operands for every kind would add stalls there. The same register in both operands must add 4; a design that merges the two operand checks would add only 2. Operand B of a control transfer must be ignored. A register index with its valid flag low must also be ignored; a design that ignored the valid flag would add a stall. The bench also checks these cases:
- A load mask that must survive idle cycles but vanish after any non-load instruction, including one with an unused class code. A design that ages the mask on every clock, or only on loads, would get this wrong.
- An instruction offered during a clear. If the design accepted it, the counters would be non-zero after the clear.
- Counters driven past their limit. A design that wraps would show a small value instead of all ones.

// File: rtl/stall_tracker_pkg.sv
package stall_tracker_pkg;

  typedef enum logic [2:0] {
    K_EXEC  = 3'd0,
    K_CMP   = 3'd1,
    K_MAC   = 3'd2,
    K_CTI   = 3'd3,
    K_LOAD  = 3'd4,
    K_STORE = 3'd5
  } ikind_e;

  localparam int NUM_OPS = 2;

  // Operand A is checked by two-source classes and by control transfers
  function automatic logic kind_checks_a(logic [2:0] k);
    return (k == K_EXEC) || (k == K_CMP) || (k == K_MAC) || (k == K_CTI);
  endfunction

  // Operand B is checked only by the two-source classes
  function automatic logic kind_checks_b(logic [2:0] k);
    return (k == K_EXEC) || (k == K_CMP) || (k == K_MAC);
  endfunction

endpackage

// File: rtl/stall_hazard_probe.sv
module stall_hazard_probe #(
  parameter int NREG  = 16,
  parameter int IDX_W = $clog2(NREG)
) (
  input  logic [NREG-1:0]  mask,
  input  logic             check_en,
  input  logic             op_vld,
  input  logic [IDX_W-1:0] op_idx,
  output logic             hit
);

  logic bit_set;

  always_comb begin
    bit_set = 1'b0;
    for (int r = 0; r < NREG; r++) begin
      if (op_idx == IDX_W'(r)) bit_set = mask[r];
    end
    hit = check_en && op_vld && bit_set;
  end

endmodule

// File: rtl/stall_load_mask.sv
module stall_load_mask #(
  parameter int NREG  = 16,
  parameter int IDX_W = $clog2(NREG)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             step,
  input  logic             ld_en,
  input  logic [IDX_W-1:0] ld_dst,
  output logic [NREG-1:0]  mask
);

  logic [NREG-1:0] staged;

  // Bits produced by the instruction in flight; promoted when it retires
  always_comb begin
    staged = '0;
    if (ld_en) staged[ld_dst] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      mask <= '0;
    else if (clr)    mask <= '0;
    else if (step)   mask <= staged;
  end

  // R5
  mask_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(mask));

  // R5
  mask_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!step && !clr) |=> $stable(mask));

endmodule

// File: rtl/stall_sat_counter.sv
module stall_sat_counter #(
  parameter int W     = 32,
  parameter int INC_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             en,
  input  logic [INC_W-1:0] inc,
  output logic [W-1:0]     cnt
);

  localparam logic [W-1:0] MAXV = {W{1'b1}};

  logic [W:0] sum;

  always_comb sum = {1'b0, cnt} + (W+1)'(inc);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt <= '0;
    else if (clr)  cnt <= '0;
    else if (en)   cnt <= sum[W] ? MAXV : sum[W-1:0];
  end

  // R1
  clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cnt == '0));

  // R7
  sat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && cnt == MAXV) |=> (cnt == MAXV));

  // R7
  no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> (cnt >= $past(cnt)));

endmodule

// File: rtl/stall_tracker.sv
module stall_tracker #(
  parameter int NREG   = 16,
  parameter int CNT_W  = 32,
  parameter int LD_PEN = 2,
  parameter int BR_PEN = 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      clr,
  input  logic                      iss_valid,
  output logic                      iss_ready,
  input  logic [2:0]                iss_kind,
  input  logic                      iss_src_a_vld,
  input  logic [$clog2(NREG)-1:0]   iss_src_a,
  input  logic                      iss_src_b_vld,
  input  logic [$clog2(NREG)-1:0]   iss_src_b,
  input  logic [$clog2(NREG)-1:0]   iss_ld_dst,
  input  logic                      iss_taken,
  output logic                      hazard_a,
  output logic                      hazard_b,
  output logic [NREG-1:0]           load_mask,
  output logic [CNT_W-1:0]          ld_stall_cnt,
  output logic [CNT_W-1:0]          br_stall_cnt,
  output logic [CNT_W-1:0]          taken_cnt,
  output logic [CNT_W-1:0]          untaken_cnt
);
  import stall_tracker_pkg::*;

  localparam int IDX_W    = $clog2(NREG);
  localparam int LD_INC_W = $clog2(NUM_OPS * LD_PEN + 1);
  localparam int BR_INC_W = $clog2(BR_PEN + 1);

  logic                    accept;
  logic                    is_cti, is_load;
  logic [NUM_OPS-1:0]      op_chk, op_vld, op_hit;
  logic [IDX_W-1:0]        op_idx [NUM_OPS];
  logic [LD_INC_W-1:0]     ld_inc;

  assign iss_ready = !clr;
  assign accept    = iss_valid && iss_ready;
  assign is_cti    = (iss_kind == K_CTI);
  assign is_load   = (iss_kind == K_LOAD);

  assign op_chk[0] = accept && kind_checks_a(iss_kind);
  assign op_chk[1] = accept && kind_checks_b(iss_kind);
  assign op_vld    = {iss_src_b_vld, iss_src_a_vld};
  assign op_idx[0] = iss_src_a;
  assign op_idx[1] = iss_src_b;

  for (genvar g = 0; g < NUM_OPS; g++) begin : g_op
    stall_hazard_probe #(.NREG(NREG), .IDX_W(IDX_W)) u_probe (
      .mask     (load_mask),
      .check_en (op_chk[g]),
      .op_vld   (op_vld[g]),
      .op_idx   (op_idx[g]),
      .hit      (op_hit[g])
    );
  end

  assign hazard_a = op_hit[0];
  assign hazard_b = op_hit[1];

  always_comb begin
    ld_inc = '0;
    for (int i = 0; i < NUM_OPS; i++) begin
      if (op_hit[i]) ld_inc = ld_inc + LD_INC_W'(LD_PEN);
    end
  end

  stall_load_mask #(.NREG(NREG), .IDX_W(IDX_W)) u_mask (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr    (clr),
    .step   (accept),
    .ld_en  (is_load),
    .ld_dst (iss_ld_dst),
    .mask   (load_mask)
  );

  stall_sat_counter #(.W(CNT_W), .INC_W(LD_INC_W)) u_ld_cnt (
    .clk (clk), .rst_n (rst_n), .clr (clr),
    .en  (|op_hit), .inc (ld_inc), .cnt (ld_stall_cnt)
  );

  stall_sat_counter #(.W(CNT_W), .INC_W(BR_INC_W)) u_br_cnt (
    .clk (clk), .rst_n (rst_n), .clr (clr),
    .en  (accept && is_cti && iss_taken), .inc (BR_INC_W'(BR_PEN)),
    .cnt (br_stall_cnt)
  );

  stall_sat_counter #(.W(CNT_W), .INC_W(1)) u_tk_cnt (
    .clk (clk), .rst_n (rst_n), .clr (clr),
    .en  (accept && is_cti && iss_taken), .inc (1'b1), .cnt (taken_cnt)
  );

  stall_sat_counter #(.W(CNT_W), .INC_W(1)) u_nt_cnt (
    .clk (clk), .rst_n (rst_n), .clr (clr),
    .en  (accept && is_cti && !iss_taken), .inc (1'b1), .cnt (untaken_cnt)
  );

  // R3
  op_a_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hazard_a |-> (iss_src_a_vld && load_mask[iss_src_a]));

  // R4
  op_b_kind_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hazard_b |-> (iss_kind != K_CTI && iss_kind != K_LOAD && iss_kind != K_STORE));

  // R9
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!iss_valid && !clr) |=> ($stable(ld_stall_cnt) && $stable(br_stall_cnt)
                              && $stable(taken_cnt) && $stable(untaken_cnt)));

  // R1
  clear_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |-> (!hazard_a && !hazard_b));

endmodule

// File: tb/stall_tracker_tb.sv
module stall_tracker_tb;

  localparam int CW   = 8;
  localparam int CMAX = (1 << CW) - 1;
  localparam int NV   = 18;

  // {kind,av,a,bv,b,ld,tk, exp_ha,exp_hb,exp_ldinc[3],exp_brinc[2]}
  localparam logic [24:0] VEC [NV] = '{
    {3'd4,1'b0,4'd0,1'b0,4'd0,4'd3,1'b0, 1'b0,1'b0,3'd0,2'd0},
    {3'd0,1'b1,4'd3,1'b1,4'd5,4'd0,1'b0, 1'b1,1'b0,3'd2,2'd0},
    {3'd4,1'b0,4'd0,1'b0,4'd0,4'd7,1'b0, 1'b0,1'b0,3'd0,2'd0},
    {3'd0,1'b1,4'd7,1'b1,4'd7,4'd0,1'b0, 1'b1,1'b1,3'd4,2'd0},
    {3'd4,1'b0,4'd0,1'b0,4'd0,4'd2,1'b0, 1'b0,1'b0,3'd0,2'd0},
    {3'd5,1'b1,4'd2,1'b1,4'd2,4'd0,1'b0, 1'b0,1'b0,3'd0,2'd0},
    {3'd4,1'b0,4'd0,1'b0,4'd0,4'd2,1'b0, 1'b0,1'b0,3'd0,2'd0},
    {3'd3,1'b1,4'd2,1'b1,4'd2,4'd0,1'b1, 1'b1,1'b0,3'd2,2'd2},
    {3'd4,1'b0,4'd0,1'b0,4'd0,4'd9,1'b0, 1'b0,1'b0,3'd0,2'd0},
    {3'd1,1'b0,4'd9,1'b1,4'd9,4'd0,1'b0, 1'b0,1'b1,3'd2,2'd0},
    {3'd4,1'b0,4'd0,1'b0,4'd0,4'd4,1'b0, 1'b0,1'b0,3'd0,2'd0},
    {3'd4,1'b1,4'd4,1'b1,4'd4,4'd4,1'b0, 1'b0,1'b0,3'd0,2'd0},
    {3'd2,1'b1,4'd1,1'b1,4'd4,4'd0,1'b0, 1'b0,1'b1,3'd2,2'd0},
    {3'd3,1'b1,4'd0,1'b0,4'd0,4'd0,1'b0, 1'b0,1'b0,3'd0,2'd0},
    {3'd4,1'b0,4'd0,1'b0,4'd0,4'd15,1'b0,1'b0,1'b0,3'd0,2'd0},
    {3'd6,1'b1,4'd15,1'b1,4'd15,4'd0,1'b0,1'b0,1'b0,3'd0,2'd0},
    {3'd0,1'b1,4'd15,1'b0,4'd0,4'd0,1'b0,1'b0,1'b0,3'd0,2'd0},
    {3'd0,1'b0,4'd0,1'b0,4'd0,4'd0,1'b1, 1'b0,1'b0,3'd0,2'd0}
  };

  logic clk = 1'b0, rst_n = 1'b0, clr = 1'b0;
  logic iss_valid = 1'b0, iss_ready;
  logic [2:0] iss_kind = '0;
  logic iss_src_a_vld = 1'b0, iss_src_b_vld = 1'b0, iss_taken = 1'b0;
  logic [3:0] iss_src_a = '0, iss_src_b = '0, iss_ld_dst = '0;
  logic hazard_a, hazard_b;
  logic [15:0] load_mask;
  logic [CW-1:0] ld_stall_cnt, br_stall_cnt, taken_cnt, untaken_cnt;

  int n_cmp = 0, n_bad = 0;
  int e_ld = 0, e_br = 0, e_tk = 0, e_nt = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  stall_tracker #(.NREG(16), .CNT_W(CW)) u_dut (
    .clk, .rst_n, .clr, .iss_valid, .iss_ready, .iss_kind,
    .iss_src_a_vld, .iss_src_a, .iss_src_b_vld, .iss_src_b,
    .iss_ld_dst, .iss_taken, .hazard_a, .hazard_b, .load_mask,
    .ld_stall_cnt, .br_stall_cnt, .taken_cnt, .untaken_cnt
  );

  function automatic int sat(int v);
    return (v > CMAX) ? CMAX : v;
  endfunction

  task automatic chk(string req, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic chk_counts(string req);
    chk({req, " ld_stall"}, int'(ld_stall_cnt), e_ld);
    chk({req, " br_stall"}, int'(br_stall_cnt), e_br);
    chk({req, " taken"},    int'(taken_cnt),    e_tk);
    chk({req, " untaken"},  int'(untaken_cnt),  e_nt);
  endtask

  task automatic drive(logic [2:0] k, logic av, logic [3:0] a, logic bv,
                       logic [3:0] b, logic [3:0] ld, logic tk);
    iss_valid = 1'b1; iss_kind = k;
    iss_src_a_vld = av; iss_src_a = a;
    iss_src_b_vld = bv; iss_src_b = b;
    iss_ld_dst = ld; iss_taken = tk;
  endtask

  // Issue one instruction and update the expected model
  task automatic issue(logic [2:0] k, logic av, logic [3:0] a, logic bv,
                       logic [3:0] b, logic [3:0] ld, logic tk, int ldinc);
    @(negedge clk);
    drive(k, av, a, bv, b, ld, tk);
    @(posedge clk); #1;
    iss_valid = 1'b0;
    e_ld = sat(e_ld + ldinc);
    if (k == 3'd3 && tk)  begin e_br = sat(e_br + 2); e_tk = sat(e_tk + 1); end
    if (k == 3'd3 && !tk) e_nt = sat(e_nt + 1);
  endtask

  task automatic finish_run;
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(20 * 200000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk_counts("R1 reset");
    chk("R1 reset mask", int'(load_mask), 0);
    chk("R1 reset ready", int'(iss_ready), 1);

    // Vector walk: R2 R3 R4 R5 R6 R8
    for (int i = 0; i < NV; i++) begin
      logic [24:0] v;
      v = VEC[i];
      @(negedge clk);
      drive(v[24:22], v[21], v[20:17], v[16], v[15:12], v[11:8], v[7]);
      #2;
      chk($sformatf("R8 vec%0d hazard_a", i), int'(hazard_a), int'(v[6]));
      chk($sformatf("R4 vec%0d hazard_b", i), int'(hazard_b), int'(v[5]));
      @(posedge clk); #1;
      iss_valid = 1'b0;
      e_ld = sat(e_ld + int'(v[4:2]));
      e_br = sat(e_br + int'(v[1:0]));
      if (v[24:22] == 3'd3 && v[7])  e_tk = sat(e_tk + 1);
      if (v[24:22] == 3'd3 && !v[7]) e_nt = sat(e_nt + 1);
      chk_counts($sformatf("R2 R6 vec%0d", i));
      chk($sformatf("R5 vec%0d mask", i), int'(load_mask),
          (v[24:22] == 3'd4) ? (1 << v[11:8]) : 0);
    end

    // R9 and R5: idle cycles keep the mask and change nothing
    issue(3'd4, 0, 0, 0, 0, 4'd6, 0, 0);
    @(negedge clk);
    drive(3'd0, 1, 4'd6, 1, 4'd6, 0, 1);
    iss_valid = 1'b0;
    repeat (3) begin
      @(negedge clk);
      chk("R9 idle hazard_a", int'(hazard_a), 0);
    end
    chk_counts("R9 idle");
    chk("R5 idle mask hold", int'(load_mask), 1 << 6);
    @(negedge clk);
    drive(3'd0, 1, 4'd6, 0, 0, 0, 0);
    #2 chk("R2 after idle hazard_a", int'(hazard_a), 1);
    @(posedge clk); #1; iss_valid = 1'b0;
    e_ld = sat(e_ld + 2);
    chk_counts("R2 after idle");

    // R1 clear blocks the offered instruction
    issue(3'd4, 0, 0, 0, 0, 4'd6, 0, 0);
    @(negedge clk);
    clr = 1'b1;
    drive(3'd3, 1, 4'd6, 0, 0, 0, 1);
    #2;
    chk("R1 clear ready", int'(iss_ready), 0);
    chk("R1 clear hazard", int'(hazard_a), 0);
    @(posedge clk); #1;
    clr = 1'b0; iss_valid = 1'b0;
    e_ld = 0; e_br = 0; e_tk = 0; e_nt = 0;
    chk_counts("R1 clear");
    chk("R1 clear mask", int'(load_mask), 0);

    // R7 saturation of load stall counter
    for (int i = 0; i < 64; i++) begin
      issue(3'd4, 0, 0, 0, 0, 4'd1, 0, 0);
      issue(3'd2, 1, 4'd1, 1, 4'd1, 0, 0, 4);
    end
    chk("R7 ld saturate", int'(ld_stall_cnt), CMAX);
    issue(3'd4, 0, 0, 0, 0, 4'd1, 0, 0);
    issue(3'd0, 1, 4'd1, 1, 4'd1, 0, 0, 4);
    chk("R7 ld stays", int'(ld_stall_cnt), CMAX);

    // R7 saturation of branch stall counter, R6 taken counts
    for (int i = 0; i < 140; i++) issue(3'd3, 0, 0, 0, 0, 0, 1, 0);
    chk("R7 br saturate", int'(br_stall_cnt), CMAX);
    chk("R6 taken count", int'(taken_cnt), 140);
    chk_counts("R7 final");

    finish_run();
  end

endmodule